// File: doc/BRIEF.md
# Two-Wire Control Register Target

This block is a two-wire serial bus target that holds a small bank of 8-bit control registers for a clock-generation subsystem. A host reaches it at the 7-bit bus address 6Bh, so the first byte is D6h for a write or D7h for a read. It supports two access styles. Indexed byte access touches one register. Block access carries a byte count: the host sends the count on writes, and the target sends it back first on reads.

The bus lines are oversampled with the system clock through two-flop synchronisers. Start and stop conditions are seen as SDA edges while SCL is high. The target only pulls SDA low, through an active-high drive-low enable, and it changes that drive only while SCL is low. The register contents are presented in parallel. Decoded control outputs are also provided: an enable for the reference output, enables for the two differential outputs, and the effective differential amplitude in millivolts.

The command byte that follows a write address sets the access style and the start index. Bit 7 = 1 selects byte access and bit 7 = 0 selects block access. Bits 6:0 give the register index. Block accesses go from that index upward. The host may stop a block after any complete byte.

Top module: `i2c_ctrl_regs`

## Requirements
- R1: After reset the registers hold index0=04h, index1=00h, index2=C0h, index3=D8h, index4=06h and index5=08h, and sda_oe is 0.
- R2: An address byte whose upper 7 bits equal 6Bh is acknowledged, with SDA pulled low in the ninth clock. Any other address gets no acknowledge, and the registers are left untouched until the next start.
- R3: Byte write: the sequence is address D6h, a command with bit 7 = 1 and the index in bits 6:0, then one data byte. That byte is stored at the index. Further data bytes in the same transfer are acknowledged but not stored.
- R4: Byte read: the sequence is address D6h, a byte-mode command, a repeated start, then address D7h. The target then returns the register at the index, MSB first.
- R5: Block write: the sequence is address D6h, a command with bit 7 = 0, a count byte N, then data bytes. The first N data bytes go to index, index+1 and so on. Data bytes beyond N are acknowledged and ignored. A stop after any byte keeps the bytes already stored.
- R6: Block read: after a block-mode command and a repeated start with D7h, the first byte returned is the current value of index4. Data from the index upward follows, one byte per host acknowledge. After a host NACK, SDA is released.
- R7: Indexes of 6 and above are acknowledged. Writes to them change nothing, and reads of them return 00h.
- R8: sda_oe changes only while the synchronised SCL is low.
- R9: ref_en is index0 bit 2. diff_en[0] is index2 bit 7 and diff_en[1] is index2 bit 6. When index5 bit 7 is 1, amp_mv = 300 + 100 × (index5 bits 6:4). When that bit is 0, amp_mv = 700.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| ref_en | output | 1 | Enable for the reference clock output |
| diff_en | output | 2 | Enables for differential outputs 0 and 1 |
| amp_mv | output | 10 | Effective differential amplitude in mV |
| reg_image | output | 48 | All registers, index i at bits 8i+7:8i |

## Verification
The assertions check on every cycle the properties that follow from local state alone:
- SDA drive moves only while SCL is low.
- A foreign address is never acknowledged.
- SDA is released while the host answers a byte the target sent.
- A write to an out-of-range index leaves the register image unchanged.
- No block data byte beyond the count is stored.

The effects that depend on a whole transaction can only be shown by the bench scenarios. These are the stored values, the contents of read data, the count byte placed first in a block read, and the decoded amplitude.

// File: rtl/ctrlreg_pkg.sv
package ctrlreg_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_RX_ACK,
    S_TX,
    S_TX_ACK
  } bus_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } phase_t;

  // fixed power-on contents of each register
  function automatic logic [7:0] reg_reset_value(input int idx);
    case (idx)
      0:       return 8'h04;
      1:       return 8'h00;
      2:       return 8'hC0;
      3:       return 8'hD8;
      4:       return 8'h06;
      5:       return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  // amplitude code to millivolts, with a default when not selected
  function automatic logic [9:0] amp_millivolts(input logic sel, input logic [2:0] code,
                                                input logic [9:0] dflt);
    return sel ? (10'd300 + 10'(code) * 10'd100) : dflt;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_p     <= 1'b1;
      sda_p     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_p     <= scl_chain[STAGES-1];
      sda_p     <= sda_chain[STAGES-1];
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_s     = sda_chain[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import ctrlreg_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h6B,
  parameter int         IDXW  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_s,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_evt,
  input  logic            stop_evt,
  input  logic [7:0]      rd_data,
  input  logic [7:0]      count_val,
  output logic            sda_oe,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data,
  output logic [IDXW-1:0] rd_idx
);
  bus_state_t      state;
  phase_t          phase;
  logic [7:0]      sh, tx_sh, remain;
  logic [3:0]      bitcnt;
  logic            ack_q, go_tx, blk, first_tx, byte_wr_done;
  logic [IDXW-1:0] ptr;

  // named events for checking
  logic       byte_done, addr_hit, tx_ptr_step;
  logic [7:0] tx_load;

  assign byte_done   = (state == S_RX) && scl_fall && (bitcnt == 4'd8);
  assign addr_hit    = (sh[7:1] == ADDR7);
  assign tx_load     = (blk && first_tx) ? count_val : rd_data;
  assign tx_ptr_step = blk && !first_tx;

  assign wr_en   = byte_done && (phase == PH_DATA) && (blk ? (remain != 8'd0) : !byte_wr_done);
  assign wr_idx  = ptr;
  assign wr_data = sh;
  assign rd_idx  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; phase <= PH_ADDR; sh <= '0; tx_sh <= '0; remain <= '0;
      bitcnt <= '0; ack_q <= 1'b0; go_tx <= 1'b0; blk <= 1'b0; first_tx <= 1'b0;
      byte_wr_done <= 1'b0; ptr <= '0; sda_oe <= 1'b0;
    end else if (start_evt) begin
      state <= S_RX; phase <= PH_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
    end else if (stop_evt) begin
      state <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            state <= S_RX_ACK;
            ack_q <= 1'b1;
            sda_oe <= 1'b1;
            go_tx <= 1'b0;
            case (phase)
              PH_ADDR: begin
                ack_q  <= addr_hit;
                sda_oe <= addr_hit;
                go_tx  <= addr_hit & sh[0];
                if (addr_hit && sh[0]) first_tx <= 1'b1;
                if (addr_hit && !sh[0]) phase <= PH_CMD;
              end
              PH_CMD: begin
                blk          <= ~sh[7];
                ptr          <= sh[IDXW-1:0];
                byte_wr_done <= 1'b0;
                phase        <= sh[7] ? PH_DATA : PH_CNT;
              end
              PH_CNT: begin
                remain <= sh;
                phase  <= PH_DATA;
              end
              default: begin
                if (blk && remain != 8'd0) begin
                  ptr    <= ptr + 1'b1;
                  remain <= remain - 8'd1;
                end
                if (!blk) byte_wr_done <= 1'b1;
              end
            endcase
          end
        end
        S_RX_ACK, S_TX_ACK: begin
          if (state == S_TX_ACK && scl_rise) ack_q <= ~sda_s;
          if (scl_fall) begin
            if (!ack_q) begin
              state <= S_IDLE; sda_oe <= 1'b0;
            end else if (state == S_TX_ACK || go_tx) begin
              state    <= S_TX;
              tx_sh    <= tx_load;
              sda_oe   <= ~tx_load[7];
              bitcnt   <= '0;
              first_tx <= 1'b0;
              if (tx_ptr_step) ptr <= ptr + 1'b1;
            end else begin
              state <= S_RX; bitcnt <= '0; sda_oe <= 1'b0;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              state <= S_TX_ACK; sda_oe <= 1'b0; ack_q <= 1'b0;
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R8: drive changes only with SCL low
  assert_sda_moves_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R2: foreign address never acknowledged
  assert_no_ack_foreign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_ADDR && !addr_hit) |=> !sda_oe);

  // R6: bus released while host answers
  assert_release_host_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TX_ACK) |-> !sda_oe);

  // R5: no store beyond the block count
  assert_block_count_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_DATA && blk && remain == 8'd0) |-> !wr_en);

endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import ctrlreg_pkg::*;
#(
  parameter int         NUM_REGS       = 6,
  parameter int         IDXW           = 7,
  parameter logic [9:0] DEFAULT_AMP_MV = 10'd700
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [IDXW-1:0]       widx,
  input  logic [7:0]            wdata,
  input  logic [IDXW-1:0]       ridx,
  output logic [7:0]            rdata,
  output logic [NUM_REGS*8-1:0] regs_flat,
  output logic                  ref_en,
  output logic [1:0]            diff_en,
  output logic [9:0]            amp_mv
);
  logic [7:0] regs [NUM_REGS];
  logic       wr_outside;

  assign wr_outside = we && (widx >= IDXW'(NUM_REGS));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              regs[i] <= reg_reset_value(i);
      else if (we && widx == IDXW'(i))         regs[i] <= wdata;
    end
    assign regs_flat[i*8 +: 8] = regs[i];
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (ridx == IDXW'(i)) rdata = regs[i];
  end

  assign ref_en  = regs[0][2];
  assign diff_en = {regs[2][6], regs[2][7]};
  assign amp_mv  = amp_millivolts(regs[5][7], regs[5][6:4], DEFAULT_AMP_MV);

  // R7: out-of-range write leaves every register as it was
  assert_ignore_outrange_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_outside |=> $stable(regs_flat));

endmodule

// File: rtl/i2c_ctrl_regs.sv
module i2c_ctrl_regs #(
  parameter int         NUM_REGS       = 6,
  parameter logic [6:0] ADDR7          = 7'h6B,
  parameter int         SYNC_STAGES    = 2,
  parameter logic [9:0] DEFAULT_AMP_MV = 10'd700
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic                  ref_en,
  output logic [1:0]            diff_en,
  output logic [9:0]            amp_mv,
  output logic [NUM_REGS*8-1:0] reg_image
);
  localparam int IDXW = 7;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic wr_en;
  logic [IDXW-1:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_target_fsm #(.ADDR7(ADDR7), .IDXW(IDXW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_data), .count_val(reg_image[4*8 +: 8]),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx)
  );

  ctrl_reg_bank #(.NUM_REGS(NUM_REGS), .IDXW(IDXW), .DEFAULT_AMP_MV(DEFAULT_AMP_MV)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(wr_idx), .wdata(wr_data),
    .ridx(rd_idx), .rdata(rd_data), .regs_flat(reg_image),
    .ref_en(ref_en), .diff_en(diff_en), .amp_mv(amp_mv)
  );

endmodule

// File: tb/tb_i2c_ctrl_regs.sv
module tb_i2c_ctrl_regs;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe, ref_en;
  logic [1:0] diff_en;
  logic [9:0] amp_mv;
  logic [47:0] reg_image;
  wire sda_line = !(m_low || sda_oe);

  i2c_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .ref_en(ref_en), .diff_en(diff_en), .amp_mv(amp_mv), .reg_image(reg_image)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] mdl [6];
  int r8_viol = 0;
  logic prev_scl = 1'b1, prev_oe = 1'b0;

  always @(negedge clk) begin
    if (rst_n && scl && prev_scl && (sda_oe != prev_oe)) r8_viol++;
    prev_scl <= scl;
    prev_oe  <= sda_oe;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_amp(input logic [7:0] b5);
    int code = int'(b5[6:4]);
    return b5[7] ? 200 + 100 * (code + 1) : 700;
  endfunction

  function automatic logic [7:0] mdl_rd(input int idx);
    return (idx < 6) ? mdl[idx] : 8'h00;
  endfunction

  task automatic check_image(input string tag);
    for (int i = 0; i < 6; i++) check(tag, int'(reg_image[i*8 +: 8]), int'(mdl[i]));
    check("R9 ref_en", int'(ref_en), int'(mdl[0][2]));
    check("R9 diff_en", int'(diff_en), int'({mdl[2][6], mdl[2][7]}));
    check("R9 amp_mv", int'(amp_mv), exp_amp(mdl[5]));
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wcyc(5); scl = 1'b1; wcyc(10); m_low = 1'b1; wcyc(10); scl = 1'b0; wcyc(5);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wcyc(5); scl = 1'b1; wcyc(10); m_low = 1'b0; wcyc(10);
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; wcyc(5); scl = 1'b1; wcyc(10); scl = 1'b0; wcyc(5);
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; wcyc(5); scl = 1'b1; wcyc(8); b = sda_line; wcyc(2); scl = 1'b0; wcyc(5);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~host_ack);
  endtask

  task automatic byte_wr(input int idx, input logic [7:0] d, input int extra);
    logic a;
    bus_start();
    send_byte(8'hD6, a); check("R2 addr ack", int'(a), 1);
    send_byte({1'b1, 7'(idx)}, a); check("R7 cmd ack", int'(a), 1);
    send_byte(d, a); check("R3 data ack", int'(a), 1);
    for (int k = 0; k < extra; k++) begin
      send_byte(~d, a); check("R3 extra ack", int'(a), 1);
    end
    bus_stop();
    if (idx < 6) mdl[idx] = d;
  endtask

  task automatic byte_rd(input int idx);
    logic a;
    logic [7:0] v;
    bus_start();
    send_byte(8'hD6, a);
    send_byte({1'b1, 7'(idx)}, a);
    bus_start();
    send_byte(8'hD7, a); check("R4 read addr ack", int'(a), 1);
    recv_byte(1'b0, v);
    bus_stop();
    check((idx < 6) ? "R4 byte read" : "R7 byte read", int'(v), int'(mdl_rd(idx)));
  endtask

  task automatic blk_wr(input int idx, input int n, input int sent, input logic [7:0] base);
    logic a;
    bus_start();
    send_byte(8'hD6, a);
    send_byte({1'b0, 7'(idx)}, a);
    send_byte(8'(n), a); check("R5 count ack", int'(a), 1);
    for (int k = 0; k < sent; k++) begin
      send_byte(base + 8'(k * 37), a); check("R5 data ack", int'(a), 1);
      if (k < n && idx + k < 6) mdl[idx + k] = base + 8'(k * 37);
    end
    bus_stop();
  endtask

  task automatic blk_rd(input int idx, input int ndata);
    logic a;
    logic [7:0] v;
    bus_start();
    send_byte(8'hD6, a);
    send_byte({1'b0, 7'(idx)}, a);
    bus_start();
    send_byte(8'hD7, a);
    recv_byte(ndata > 0, v);
    check("R6 count first", int'(v), int'(mdl[4]));
    for (int k = 0; k < ndata; k++) begin
      recv_byte(k < ndata - 1, v);
      check((idx + k < 6) ? "R6 block data" : "R7 block data", int'(v), int'(mdl_rd(idx + k)));
    end
    bus_stop();
    check("R6 released", int'(sda_oe), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R8 act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    logic a;
    r = $urandom(32'd1234);
    for (int i = 0; i < 6; i++) mdl[i] = 8'h00;
    mdl[0] = 8'h04; mdl[2] = 8'hC0; mdl[3] = 8'hD8; mdl[4] = 8'h06; mdl[5] = 8'h08;
    rst_n = 1'b0;
    wcyc(5);
    rst_n = 1'b1;
    wcyc(5);
    check("R1 sda_oe", int'(sda_oe), 0);
    check_image("R1 reset image");

    // R2: foreign address
    bus_start(); send_byte(8'hD4, a); check("R2 foreign nack", int'(a), 0);
    send_byte(8'h85, a); send_byte(8'h11, a); bus_stop();
    check_image("R2 untouched");

    // R3 with trailing byte, R4 readback
    byte_wr(1, 8'h5A, 1); check_image("R3 byte write");
    byte_rd(1);
    // R9 amplitude selection
    byte_wr(5, 8'hB0, 0); check_image("R9 amp sel");
    byte_wr(5, 8'h70, 0); check_image("R9 amp default");
    byte_wr(0, 8'h00, 0); byte_wr(2, 8'h40, 0); check_image("R9 enables");
    // R5 beyond count, partial stop
    blk_wr(0, 2, 3, 8'h21); check_image("R5 beyond count");
    blk_wr(1, 3, 1, 8'h99); check_image("R5 partial stop");
    // R7 out-of-range
    byte_wr(6, 8'hEE, 0); check_image("R7 write ignored");
    byte_rd(7);
    blk_wr(5, 3, 3, 8'h13); check_image("R7 block tail");
    // R6 read crossing end
    blk_rd(3, 5);
    blk_rd(0, 0);

    for (int it = 0; it < 24; it++) begin
      int op = int'($urandom % 4);
      int idx = int'($urandom % 8);
      logic [7:0] d = 8'($urandom);
      int n = int'($urandom % 4) + 1;
      case (op)
        0: begin byte_wr(idx, d, 0); check_image("R3 random"); end
        1: byte_rd(idx);
        2: begin blk_wr(idx, n, n, d); check_image("R5 random"); end
        default: blk_rd(idx, n);
      endcase
    end

    check("R8 sda stable while scl high", r8_viol, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule